// File: doc/BRIEF.md
# Frame Ring Pointer Manager

This block handles the pointers of a circular buffer whose unit is the 32-byte frame. The block holds no data. It tracks where a producer may write and where a consumer may read, and it answers each request with a granted frame count and a buffer offset. An external copy engine then moves the data.

Each side of the ring uses two pointers. On the write side, an allocated pointer marks space that has been reserved and a committed pointer marks data that is valid. On the read side, a peeked pointer marks data that has been handed out and a discarded pointer marks space that has been released. Frame-granular requests move both pointers of one side together, and each grant stops at the physical end of the ring. Multiframe requests come in two steps, reserve then commit and peek then release, and always move a whole multiframe. The four fill levels (allocated, valid, unseen, free) are output at all times.

Top module: `frame_ring`

## Requirements
- R1: After reset all four pointers are zero. The allocated, valid and unseen counts read 0, the free count reads DEPTH-1 (127), and no response is flagged.
- R2: All counts are taken modulo DEPTH. allocated = wAlloc - rDiscard, valid = wCommit - rDiscard, unseen = wCommit - rPeek, free = rDiscard - wAlloc - 1.
- R3: Frame write (opCode 0) grants the smallest of the request, the free count and DEPTH - wCommit. It reports the offset base + wCommit and sets both write pointers to wCommit + grant.
- R4: Frame read (opCode 1) grants the smallest of the request, the unseen count and DEPTH - rPeek. It reports the offset base + rPeek and sets both read pointers to rPeek + grant.
- R5: Multiframe reserve (opCode 2) succeeds only when free is at least 16. It then reports base + wAlloc with a count of 16 and advances wAlloc alone by 16, so the valid count does not change.
- R6: Multiframe commit (opCode 3) always succeeds. It reports base + wCommit with a count of 16 and advances wCommit by 16.
- R7: Multiframe peek (opCode 4) succeeds only when unseen is at least 16. It then reports base + rPeek with a count of 16 and advances rPeek alone by 16.
- R8: Multiframe release (opCode 5) always succeeds. It reports base + rDiscard with a count of 16 and advances rDiscard by 16.
- R9: Flush (opCode 6) sets both read pointers to wCommit rounded down to a multiple of 16. It reports success, a count of 0 and that aligned offset.
- R10: A refused request reports ok = 0, count 0 and offset 0, and leaves every pointer and count as it was. A refused request is a frame op whose grant is zero, a multiframe reserve or peek without enough frames, or the unused opCode 7.
- R11: At most one operation is accepted per cycle. Its response appears on the clock edge that accepts it. The word address equals the offset shifted left by 3, and the multiframe index equals the offset shifted right by 4. Offsets wrap modulo 2^OFS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseOfs | input | OFS_W | Frame offset of the ring's first slot |
| opValid | input | 1 | Request strobe |
| opCode | input | 3 | Operation code (see R3-R11) |
| reqFrames | input | PTR_W+1 | Frames asked for by frame read or write |
| rspValid | output | 1 | A request was handled on the last edge |
| rspOk | output | 1 | The request was granted |
| rspCount | output | PTR_W+1 | Frames granted |
| rspOfs | output | OFS_W | Granted frame offset |
| rspWordAddr | output | OFS_W+3 | Granted offset as a 32-bit word address |
| rspMfIdx | output | OFS_W-4 | Granted offset as a multiframe index |
| cntAlloc | output | PTR_W | Allocated frames |
| cntValid | output | PTR_W | Committed frames not yet released |
| cntUnseen | output | PTR_W | Committed frames not yet peeked |
| cntFree | output | PTR_W | Frames that can still be reserved |

## Verification
The commit and release operations are not guarded. The assertions therefore assume the caller commits only space it has reserved and releases only data it has peeked. They also assume frame writes are issued only while no reservation is pending and frame reads only while no peek is pending. The random stimulus tracks a pointer model and replaces any operation that would break these rules with the unused opCode 7, which exercises the refusal path. Offset wrap-around is reached by switching to a base near the top of the offset range partway through the run.

// File: rtl/frame_ring_pkg.sv
package frame_ring_pkg;

  typedef enum logic [2:0] {
    OP_FWRITE     = 3'd0,
    OP_FREAD      = 3'd1,
    OP_MF_PREP    = 3'd2,
    OP_MF_COMMIT  = 3'd3,
    OP_MF_PEEK    = 3'd4,
    OP_MF_DISCARD = 3'd5,
    OP_EMPTY      = 3'd6,
    OP_RSVD       = 3'd7
  } ringOp_e;

  // one-hot pointer update strobes, control -> pointer file
  typedef struct packed {
    logic advWrBoth;
    logic advRdBoth;
    logic advAlloc;
    logic advCommit;
    logic advPeek;
    logic advDiscard;
    logic doEmpty;
  } ptrStrobes_t;

endpackage

// File: rtl/frame_ring_ptrs.sv
module frame_ring_ptrs
  import frame_ring_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int MF_FRAMES = 16,
  parameter int PTR_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptrStrobes_t      strb,
  input  logic [PTR_W-1:0] stepAmt,
  output logic [PTR_W-1:0] wAlloc,
  output logic [PTR_W-1:0] wCommit,
  output logic [PTR_W-1:0] rPeek,
  output logic [PTR_W-1:0] rDiscard,
  output logic [PTR_W-1:0] cntAlloc,
  output logic [PTR_W-1:0] cntValid,
  output logic [PTR_W-1:0] cntUnseen,
  output logic [PTR_W-1:0] cntFree
);

  localparam logic [PTR_W-1:0] ALIGN_MASK = ~PTR_W'(MF_FRAMES - 1);

  logic [PTR_W-1:0] emptyTo;
  assign emptyTo = wCommit & ALIGN_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wAlloc   <= '0;
      wCommit  <= '0;
      rPeek    <= '0;
      rDiscard <= '0;
    end else begin
      if (strb.advWrBoth) begin
        wAlloc  <= wCommit + stepAmt;
        wCommit <= wCommit + stepAmt;
      end
      if (strb.advAlloc)  wAlloc  <= wAlloc + stepAmt;
      if (strb.advCommit) wCommit <= wCommit + stepAmt;
      if (strb.advRdBoth) begin
        rPeek    <= rPeek + stepAmt;
        rDiscard <= rPeek + stepAmt;
      end
      if (strb.advPeek)    rPeek    <= rPeek + stepAmt;
      if (strb.advDiscard) rDiscard <= rDiscard + stepAmt;
      if (strb.doEmpty) begin
        rPeek    <= emptyTo;
        rDiscard <= emptyTo;
      end
    end
  end

  // modulo-DEPTH levels
  assign cntAlloc  = wAlloc - rDiscard;
  assign cntValid  = wCommit - rDiscard;
  assign cntUnseen = wCommit - rPeek;
  assign cntFree   = rDiscard - wAlloc - PTR_W'(1);

  // R11: control raises at most one strobe per cycle
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R2: reserved plus free always spans DEPTH-1
  assert_alloc_free_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    PTR_W'(cntAlloc + cntFree) == PTR_W'(DEPTH - 1));

endmodule

// File: rtl/frame_ring_ctrl.sv
module frame_ring_ctrl
  import frame_ring_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int MF_FRAMES = 16,
  parameter int OFS_W     = 10,
  parameter int PTR_W     = $clog2(DEPTH),
  parameter int CNT_W     = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OFS_W-1:0] baseOfs,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [CNT_W-1:0] reqFrames,
  input  logic [PTR_W-1:0] wAlloc,
  input  logic [PTR_W-1:0] wCommit,
  input  logic [PTR_W-1:0] rPeek,
  input  logic [PTR_W-1:0] rDiscard,
  input  logic [PTR_W-1:0] cntFree,
  input  logic [PTR_W-1:0] cntUnseen,
  output ptrStrobes_t      strb,
  output logic [PTR_W-1:0] stepAmt,
  output logic             rspValid,
  output logic             rspOk,
  output logic [CNT_W-1:0] rspCount,
  output logic [OFS_W-1:0] rspOfs
);

  localparam logic [CNT_W-1:0] DEPTH_C    = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] MF_C       = CNT_W'(MF_FRAMES);
  localparam logic [PTR_W-1:0] ALIGN_MASK = ~PTR_W'(MF_FRAMES - 1);

  function automatic logic [CNT_W-1:0] pick3(input logic [CNT_W-1:0] a,
                                             input logic [CNT_W-1:0] b,
                                             input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  logic [CNT_W-1:0] freeX, unseenX, roomW, roomR, gW, gR;
  assign freeX   = {1'b0, cntFree};
  assign unseenX = {1'b0, cntUnseen};
  assign roomW   = DEPTH_C - {1'b0, wCommit};
  assign roomR   = DEPTH_C - {1'b0, rPeek};
  assign gW      = pick3(reqFrames, freeX, roomW);
  assign gR      = pick3(reqFrames, unseenX, roomR);

  logic             nOk;
  logic [CNT_W-1:0] nCnt;
  logic [PTR_W-1:0] nPtr;
  logic [OFS_W-1:0] nOfs;

  always_comb begin
    strb    = '0;
    stepAmt = '0;
    nOk     = 1'b0;
    nCnt    = '0;
    nPtr    = '0;
    if (opValid) begin
      case (opCode)
        OP_FWRITE: if (gW != '0) begin
          strb.advWrBoth = 1'b1; stepAmt = gW[PTR_W-1:0];
          nOk = 1'b1; nCnt = gW; nPtr = wCommit;
        end
        OP_FREAD: if (gR != '0) begin
          strb.advRdBoth = 1'b1; stepAmt = gR[PTR_W-1:0];
          nOk = 1'b1; nCnt = gR; nPtr = rPeek;
        end
        OP_MF_PREP: if (freeX >= MF_C) begin
          strb.advAlloc = 1'b1; stepAmt = MF_C[PTR_W-1:0];
          nOk = 1'b1; nCnt = MF_C; nPtr = wAlloc;
        end
        OP_MF_COMMIT: begin
          strb.advCommit = 1'b1; stepAmt = MF_C[PTR_W-1:0];
          nOk = 1'b1; nCnt = MF_C; nPtr = wCommit;
        end
        OP_MF_PEEK: if (unseenX >= MF_C) begin
          strb.advPeek = 1'b1; stepAmt = MF_C[PTR_W-1:0];
          nOk = 1'b1; nCnt = MF_C; nPtr = rPeek;
        end
        OP_MF_DISCARD: begin
          strb.advDiscard = 1'b1; stepAmt = MF_C[PTR_W-1:0];
          nOk = 1'b1; nCnt = MF_C; nPtr = rDiscard;
        end
        OP_EMPTY: begin
          strb.doEmpty = 1'b1;
          nOk = 1'b1; nPtr = wCommit & ALIGN_MASK;
        end
        default: ;
      endcase
    end
  end

  assign nOfs = nOk ? (baseOfs + OFS_W'(nPtr)) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspOk    <= 1'b0;
      rspCount <= '0;
      rspOfs   <= '0;
    end else begin
      rspValid <= opValid;
      rspOk    <= nOk;
      rspCount <= nCnt;
      rspOfs   <= nOfs;
    end
  end

  // R3: frame write never exceeds request, free space or distance to end
  assert_wr_grant_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_FWRITE) |=>
      (rspCount <= $past(reqFrames) && rspCount <= {1'b0, $past(cntFree)} &&
       rspCount <= $past(roomW)));

  // R4: frame read never exceeds request, unseen data or distance to end
  assert_rd_grant_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_FREAD) |=>
      (rspCount <= $past(reqFrames) && rspCount <= {1'b0, $past(cntUnseen)} &&
       rspCount <= $past(roomR)));

  // R5: a reserve without a whole multiframe of room is refused
  assert_prep_needs_room_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_MF_PREP && freeX < MF_C) |=> !rspOk);

  // R10: refusals report neither count nor offset
  assert_fail_is_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspOk) |-> (rspCount == '0 && rspOfs == '0));

endmodule

// File: rtl/frame_ring.sv
module frame_ring
  import frame_ring_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int MF_FRAMES   = 16,
  parameter int FRAME_WORDS = 8,
  parameter int OFS_W       = 10,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = PTR_W + 1,
  localparam int MF_W       = $clog2(MF_FRAMES),
  localparam int WORD_SH    = $clog2(FRAME_WORDS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [OFS_W-1:0]         baseOfs,
  input  logic                     opValid,
  input  logic [2:0]               opCode,
  input  logic [CNT_W-1:0]         reqFrames,
  output logic                     rspValid,
  output logic                     rspOk,
  output logic [CNT_W-1:0]         rspCount,
  output logic [OFS_W-1:0]         rspOfs,
  output logic [OFS_W+WORD_SH-1:0] rspWordAddr,
  output logic [OFS_W-MF_W-1:0]    rspMfIdx,
  output logic [PTR_W-1:0]         cntAlloc,
  output logic [PTR_W-1:0]         cntValid,
  output logic [PTR_W-1:0]         cntUnseen,
  output logic [PTR_W-1:0]         cntFree
);

  ptrStrobes_t      strb;
  logic [PTR_W-1:0] stepAmt, wAlloc, wCommit, rPeek, rDiscard;

  frame_ring_ctrl #(
    .DEPTH(DEPTH), .MF_FRAMES(MF_FRAMES), .OFS_W(OFS_W),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .baseOfs(baseOfs),
    .opValid(opValid), .opCode(opCode), .reqFrames(reqFrames),
    .wAlloc(wAlloc), .wCommit(wCommit), .rPeek(rPeek), .rDiscard(rDiscard),
    .cntFree(cntFree), .cntUnseen(cntUnseen),
    .strb(strb), .stepAmt(stepAmt),
    .rspValid(rspValid), .rspOk(rspOk), .rspCount(rspCount), .rspOfs(rspOfs)
  );

  frame_ring_ptrs #(
    .DEPTH(DEPTH), .MF_FRAMES(MF_FRAMES), .PTR_W(PTR_W)
  ) uPtrs (
    .clk(clk), .rstN(rstN), .strb(strb), .stepAmt(stepAmt),
    .wAlloc(wAlloc), .wCommit(wCommit), .rPeek(rPeek), .rDiscard(rDiscard),
    .cntAlloc(cntAlloc), .cntValid(cntValid),
    .cntUnseen(cntUnseen), .cntFree(cntFree)
  );

  assign rspWordAddr = {rspOfs, {WORD_SH{1'b0}}};
  assign rspMfIdx    = rspOfs[OFS_W-1:MF_W];

  // R10: a refused request leaves all levels untouched
  assert_fail_holds_counts_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspOk) |->
      (cntAlloc == $past(cntAlloc) && cntValid == $past(cntValid) &&
       cntUnseen == $past(cntUnseen) && cntFree == $past(cntFree)));

  // R5: a granted reserve grows the allocation only
  assert_prep_keeps_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOk && $past(opCode) == OP_MF_PREP) |->
      (cntValid == $past(cntValid) &&
       cntAlloc == PTR_W'($past(cntAlloc) + PTR_W'(MF_FRAMES))));

  // R7: a granted peek consumes one multiframe of unseen data
  assert_peek_takes_unseen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOk && $past(opCode) == OP_MF_PEEK) |->
      (cntUnseen == PTR_W'($past(cntUnseen) - PTR_W'(MF_FRAMES)) &&
       cntValid == $past(cntValid)));

endmodule

// File: tb/tb_frame_ring.sv
module tb_frame_ring;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int MF    = 16;
  localparam int OFS_W = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  baseOfs = 10'd128;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [7:0]  reqFrames = 8'd0;
  logic        rspValid, rspOk;
  logic [7:0]  rspCount;
  logic [9:0]  rspOfs;
  logic [12:0] rspWordAddr;
  logic [5:0]  rspMfIdx;
  logic [6:0]  cntAlloc, cntValid, cntUnseen, cntFree;

  frame_ring dut (
    .clk(clk), .rstN(rstN), .baseOfs(baseOfs), .opValid(opValid),
    .opCode(opCode), .reqFrames(reqFrames), .rspValid(rspValid),
    .rspOk(rspOk), .rspCount(rspCount), .rspOfs(rspOfs),
    .rspWordAddr(rspWordAddr), .rspMfIdx(rspMfIdx), .cntAlloc(cntAlloc),
    .cntValid(cntValid), .cntUnseen(cntUnseen), .cntFree(cntFree)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  int mWa = 0, mWc = 0, mRp = 0, mRd = 0;

  function automatic int msk(input int v);
    return v & (DEPTH - 1);
  endfunction

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  task automatic check(input bit good, input string tag, input int act, input int exp);
    nChecks++;
    if (!good) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkCounts();
    check(int'(cntAlloc) == msk(mWa - mRd), "R2 alloc", int'(cntAlloc), msk(mWa - mRd));
    check(int'(cntValid) == msk(mWc - mRd), "R2 valid", int'(cntValid), msk(mWc - mRd));
    check(int'(cntUnseen) == msk(mWc - mRp), "R2 unseen", int'(cntUnseen), msk(mWc - mRp));
    check(int'(cntFree) == msk(mRd - mWa - 1), "R2 free", int'(cntFree), msk(mRd - mWa - 1));
  endtask

  task automatic doOp(input int code, input int req);
    int freeN, unseenN, g, eOk, eCnt, ePtr, eOfs;
    string tag;
    freeN   = msk(mRd - mWa - 1);
    unseenN = msk(mWc - mRp);
    eOk = 0; eCnt = 0; ePtr = 0;
    case (code)
      0: begin tag = "R3"; g = min3(req, freeN, DEPTH - mWc);
         if (g > 0) begin eOk = 1; eCnt = g; ePtr = mWc; mWc = msk(mWc + g); mWa = mWc; end end
      1: begin tag = "R4"; g = min3(req, unseenN, DEPTH - mRp);
         if (g > 0) begin eOk = 1; eCnt = g; ePtr = mRp; mRp = msk(mRp + g); mRd = mRp; end end
      2: begin tag = "R5";
         if (freeN >= MF) begin eOk = 1; eCnt = MF; ePtr = mWa; mWa = msk(mWa + MF); end end
      3: begin tag = "R6"; eOk = 1; eCnt = MF; ePtr = mWc; mWc = msk(mWc + MF); end
      4: begin tag = "R7";
         if (unseenN >= MF) begin eOk = 1; eCnt = MF; ePtr = mRp; mRp = msk(mRp + MF); end end
      5: begin tag = "R8"; eOk = 1; eCnt = MF; ePtr = mRd; mRd = msk(mRd + MF); end
      6: begin tag = "R9"; eOk = 1; ePtr = mWc & ~(MF - 1); mRp = ePtr; mRd = ePtr; end
      default: tag = "R10";
    endcase
    if (eOk == 0) tag = "R10";
    eOfs = eOk ? ((int'(baseOfs) + ePtr) & ((1 << OFS_W) - 1)) : 0;
    opValid   = 1'b1;
    opCode    = code[2:0];
    reqFrames = req[7:0];
    @(negedge clk);
    opValid = 1'b0;
    check(rspValid == 1'b1, "R11 rspValid", int'(rspValid), 1);
    check(int'(rspOk) == eOk, {tag, " ok"}, int'(rspOk), eOk);
    check(int'(rspCount) == eCnt, {tag, " count"}, int'(rspCount), eCnt);
    check(int'(rspOfs) == eOfs, {tag, " offset"}, int'(rspOfs), eOfs);
    check(int'(rspWordAddr) == (eOfs << 3), "R11 word", int'(rspWordAddr), eOfs << 3);
    check(int'(rspMfIdx) == (eOfs >> 4), "R11 mfidx", int'(rspMfIdx), eOfs >> 4);
    checkCounts();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog R11 actual=0 expected=1");
    finishRun();
  end

  initial begin
    int code, req;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rspValid == 1'b0, "R1 rspValid", int'(rspValid), 0);
    check(cntAlloc == 7'd0, "R1 alloc", int'(cntAlloc), 0);
    check(cntValid == 7'd0, "R1 valid", int'(cntValid), 0);
    check(cntUnseen == 7'd0, "R1 unseen", int'(cntUnseen), 0);
    check(cntFree == 7'd127, "R1 free", int'(cntFree), 127);

    // directed corners
    doOp(0, 0);     // R10 zero request
    doOp(0, 100);   // R3 full grant
    doOp(0, 100);   // R3 limited by free (27)
    doOp(7, 5);     // R10 unused code
    doOp(2, 0);     // R5 refused, ring full
    doOp(1, 30);    // R4
    doOp(1, 200);   // R4 limited by unseen
    doOp(0, 50);    // R3 limited by end distance (1)
    doOp(1, 50);    // R4 limited by end distance (1)
    doOp(4, 0);     // R7 refused, nothing unseen
    doOp(0, 5);     // unaligned committed data
    doOp(6, 0);     // R9 flush to aligned pointer
    doOp(2, 0);     // R5
    doOp(2, 0);     // R5
    doOp(3, 0);     // R6
    doOp(4, 0);     // R7
    doOp(8 - 3, 0); // R8 release
    doOp(3, 0);     // R6

    // constrained random
    for (int i = 0; i < 2500; i++) begin
      if (i == 1200) baseOfs = 10'd1000;  // R11 offset wrap
      code = int'($urandom % 8);
      req  = int'($urandom % 140);
      if (code == 0 && mWa != mWc) code = 7;
      if (code == 1 && mRp != mRd) code = 7;
      if (code == 3 && msk(mWa - mWc) < MF) code = 7;
      if (code == 5 && msk(mRp - mRd) < MF) code = 7;
      if (code == 6 && (mWa != mWc || mRp != mRd)) code = 7;
      doOp(code, req);
      if (($urandom % 5) == 0) begin
        @(negedge clk);
        check(rspValid == 1'b0, "R11 idle", int'(rspValid), 0);
        checkCounts();
      end
    end
    finishRun();
  end
endmodule